// File: doc/BRIEF.md
# USB Slave-FIFO Bridge with 32-to-16 Width Conversion

This block sits between on-chip measurement logic and an external USB 2.0 controller whose endpoints are exposed as a 16-bit synchronous slave-FIFO bus. Upstream, 32-bit timestamp words are pushed into an internal buffer that holds 1024 of them. The buffer is emptied sixteen bits at a time into the controller's data endpoint, which leads to the host. Downstream, 16-bit command words from the host are pulled out of the controller's command endpoint and handed to local control logic as single-cycle valid pulses.

Both endpoints share one bidirectional data bus and one endpoint-select field. The block therefore arbitrates between them. A waiting command always wins over outgoing data. When the select field changes, it must stay settled for a cycle before any strobe uses it. The block never strobes into a full endpoint or out of an empty one. It drives the data bus only while it is writing. Words offered to the buffer while it is full are discarded, and a drop counter records them.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it is released: usb_rd_n, usb_wr_n and usb_oe_n are 1, usb_ep is 2'b00, cmd_valid is 0, up_empty is 1, up_full is 0 and drop_count is 0.
- R2: Each accepted 32-bit word leaves on usb_fd as two write strobes (usb_wr_n low for one cycle each). Bits 15:0 go first, then bits 31:16, with usb_ep = 2'b10 (data endpoint). Words leave in the order they were accepted.
- R3: A command read drives usb_ep = 2'b00 (command endpoint) and pulls usb_rd_n and usb_oe_n low together for one cycle. usb_fd is captured at the end of that cycle, and cmd_valid is 1 for exactly the next cycle with cmd_word equal to the captured value.
- R4: A write strobe never starts when usb_in_full was 1 at the decision edge. A read strobe never starts when usb_out_empty was 1 at that edge.
- R5: A write strobe never starts while usb_out_empty = 0 was seen at the decision edge. A pending command is always served before outgoing data.
- R6: Whenever a strobe is low, usb_ep holds the value it had in the previous cycle, so every endpoint change is followed by at least one idle cycle.
- R7: usb_oe_n and usb_wr_n are never low together. The block drives usb_fd only during a write strobe and leaves it released while reading.
- R8: up_full is 1 when DEPTH 32-bit words are held, and up_empty is 1 when none are held. A word whose low half has been sent but whose high half has not still counts as held.
- R9: A push while up_full is 1 stores nothing and never appears on the bus. drop_count then increments and saturates at its all-ones value.
- R10: Every strobe is followed by at least one cycle in which usb_rd_n and usb_wr_n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the slave-FIFO bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_push | input | 1 | Offer up_word to the buffer this cycle |
| up_word | input | IN_W | 32-bit timestamp word |
| up_full | output | 1 | Buffer holds DEPTH words |
| up_empty | output | 1 | Buffer holds no word |
| drop_count | output | DROP_W | Saturating count of pushes discarded while full |
| cmd_valid | output | 1 | One-cycle pulse: cmd_word carries a new command |
| cmd_word | output | BUS_W | Last command read from the host |
| usb_fd | inout | BUS_W | Shared slave-FIFO data bus |
| usb_ep | output | 2 | Endpoint select: 2'b00 command, 2'b10 data |
| usb_rd_n | output | 1 | Active-low read strobe |
| usb_wr_n | output | 1 | Active-low write strobe |
| usb_oe_n | output | 1 | Active-low output enable for the controller |
| usb_out_empty | input | 1 | Command endpoint has nothing to read |
| usb_in_full | input | 1 | Data endpoint cannot accept a write |

## Verification
Two collisions matter most. The first is a command arriving while data is streaming out. The bench loads commands into the host model while the data endpoint is selected and words are draining. It then judges every write strobe against the empty flag as the design sampled it, and checks that the endpoint select did not move in the cycle before the strobe. The second is a new word being pushed on the same edge that the high half of the oldest word is popped. Back-to-back pushes during an open drain provoke it, and the scoreboard confirms that no half is lost, repeated or reordered.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2
   } seq_state_t;

   localparam logic [1:0] EP_SEL_CMD  = 2'b00;
   localparam logic [1:0] EP_SEL_DATA = 2'b10;
endpackage

// File: rtl/bridge_buffer.sv
module bridge_buffer #(
   parameter int DEPTH    = 1024,
   parameter int IN_W     = 32,
   parameter int OUT_W    = 16,
   parameter int DROP_W   = 16,
   parameter bit DROP_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [IN_W-1:0]   push_word,
   input  logic              pop,
   output logic [OUT_W-1:0]  head_half,
   output logic              full,
   output logic              empty,
   output logic [DROP_W-1:0] drops
);
   localparam int AW    = $clog2(DEPTH);
   localparam int RATIO = IN_W / OUT_W;
   localparam int SEL_W = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [AW:0]    FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(RATIO - 1);

   generate
      if ((IN_W % OUT_W) != 0 || RATIO < 2) begin : g_bad_ratio
         $error("bridge_buffer: IN_W must be a multiple (>=2) of OUT_W");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("bridge_buffer: DEPTH must be a power of two");
      end
   endgenerate

   logic [IN_W-1:0]  store [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      cnt;
   logic [SEL_W-1:0] sel;
   logic             push_ok, word_done;
   logic [IN_W-1:0]  head_word;

   assign full      = (cnt == FULL_CNT);
   assign empty     = (cnt == '0);
   assign push_ok   = push && !full;
   assign word_done = pop && (sel == LAST_SEL);
   assign head_word = store[rd_ptr];
   assign head_half = head_word[sel*OUT_W +: OUT_W];

   always_ff @(posedge clk) begin
      if (push_ok) store[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         sel    <= '0;
      end else begin
         if (push_ok)   wr_ptr <= wr_ptr + 1'b1;
         if (word_done) rd_ptr <= rd_ptr + 1'b1;
         if (pop)       sel    <= word_done ? '0 : sel + 1'b1;
         if (push_ok && !word_done)      cnt <= cnt + 1'b1;
         else if (!push_ok && word_done) cnt <= cnt - 1'b1;
      end
   end

   generate
      if (DROP_SAT) begin : g_drop_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         drops <= '0;
            else if (push && full && !(&drops)) drops <= drops + 1'b1;
         end
      end else begin : g_drop_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             drops <= '0;
            else if (push && full)  drops <= drops + 1'b1;
         end
      end
   endgenerate

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);
   // R8
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R9
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push || !full) |=> $stable(drops));
   // R9
   drop_keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full);
endmodule

// File: rtl/bridge_sequencer.sv
module bridge_sequencer
   import usb_bridge_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_out_empty,
   input  logic             ep_in_full,
   input  logic             buf_empty,
   input  logic [BUS_W-1:0] buf_half,
   input  logic [BUS_W-1:0] bus_in,
   output logic             buf_pop,
   output logic [1:0]       ep_sel,
   output logic             rd_n,
   output logic             wr_n,
   output logic             oe_n,
   output logic             drv_en,
   output logic [BUS_W-1:0] drv_data,
   output logic             cmd_valid,
   output logic [BUS_W-1:0] cmd_data
);
   seq_state_t state;
   logic want_cmd, want_data;

   assign want_cmd  = !ep_out_empty;
   assign want_data = !buf_empty && !ep_in_full;
   assign buf_pop   = (state == SEQ_IDLE) && !want_cmd && want_data
                      && (ep_sel == EP_SEL_DATA);
   assign drv_en    = (state == SEQ_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         ep_sel    <= EP_SEL_CMD;
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
         oe_n      <= 1'b1;
         drv_data  <= '0;
         cmd_valid <= 1'b0;
         cmd_data  <= '0;
      end else begin
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
         oe_n      <= 1'b1;
         cmd_valid <= 1'b0;
         state     <= SEQ_IDLE;
         unique case (state)
            SEQ_IDLE: begin
               if (want_cmd) begin
                  if (ep_sel != EP_SEL_CMD) ep_sel <= EP_SEL_CMD;
                  else begin
                     rd_n  <= 1'b0;
                     oe_n  <= 1'b0;
                     state <= SEQ_READ;
                  end
               end else if (want_data) begin
                  if (ep_sel != EP_SEL_DATA) ep_sel <= EP_SEL_DATA;
                  else begin
                     wr_n     <= 1'b0;
                     drv_data <= buf_half;
                     state    <= SEQ_WRITE;
                  end
               end
            end
            SEQ_READ: begin
               cmd_valid <= 1'b1;
               cmd_data  <= bus_in;
            end
            default: ;
         endcase
      end
   end

   // R4
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> !$past(ep_out_empty));
   // R4
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> !$past(ep_in_full));
   // R5
   cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(ep_out_empty));
   // R6
   ep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> $stable(ep_sel));
   // R7
   oe_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !wr_n));
   // R10
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |=> (rd_n && wr_n));
   // R3
   valid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |=> cmd_valid);
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
   parameter int DEPTH    = 1024,
   parameter int IN_W     = 32,
   parameter int BUS_W    = 16,
   parameter int DROP_W   = 16,
   parameter bit DROP_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_push,
   input  logic [IN_W-1:0]   up_word,
   output logic              up_full,
   output logic              up_empty,
   output logic [DROP_W-1:0] drop_count,
   output logic              cmd_valid,
   output logic [BUS_W-1:0]  cmd_word,
   inout  wire  [BUS_W-1:0]  usb_fd,
   output logic [1:0]        usb_ep,
   output logic              usb_rd_n,
   output logic              usb_wr_n,
   output logic              usb_oe_n,
   input  logic              usb_out_empty,
   input  logic              usb_in_full
);
   logic             pop;
   logic [BUS_W-1:0] head_half;
   logic             drv_en;
   logic [BUS_W-1:0] drv_data;

   bridge_buffer #(
      .DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(BUS_W),
      .DROP_W(DROP_W), .DROP_SAT(DROP_SAT)
   ) buf_i (
      .clk(clk), .rst_n(rst_n),
      .push(up_push), .push_word(up_word),
      .pop(pop), .head_half(head_half),
      .full(up_full), .empty(up_empty), .drops(drop_count)
   );

   bridge_sequencer #(.BUS_W(BUS_W)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .ep_out_empty(usb_out_empty), .ep_in_full(usb_in_full),
      .buf_empty(up_empty), .buf_half(head_half), .bus_in(usb_fd),
      .buf_pop(pop), .ep_sel(usb_ep),
      .rd_n(usb_rd_n), .wr_n(usb_wr_n), .oe_n(usb_oe_n),
      .drv_en(drv_en), .drv_data(drv_data),
      .cmd_valid(cmd_valid), .cmd_data(cmd_word)
   );

   assign usb_fd = drv_en ? drv_data : {BUS_W{1'bz}};
endmodule

// File: tb/usb_fifo_bridge_tb_top.sv
module usb_fifo_bridge_tb_top;
   localparam int DEPTH  = 16;
   localparam int DROP_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_push = 1'b0;
   logic [31:0] up_word = '0;
   logic up_full, up_empty, cmd_valid;
   logic [DROP_W-1:0] drop_count;
   logic [15:0] cmd_word;
   wire  [15:0] usb_fd;
   logic [1:0]  usb_ep;
   logic usb_rd_n, usb_wr_n, usb_oe_n;
   logic usb_out_empty = 1'b1;
   logic usb_in_full = 1'b1;

   always #4 clk = ~clk;

   usb_fifo_bridge #(.DEPTH(DEPTH), .DROP_W(DROP_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .up_push(up_push), .up_word(up_word),
      .up_full(up_full), .up_empty(up_empty), .drop_count(drop_count),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .usb_fd(usb_fd),
      .usb_ep(usb_ep), .usb_rd_n(usb_rd_n), .usb_wr_n(usb_wr_n),
      .usb_oe_n(usb_oe_n), .usb_out_empty(usb_out_empty),
      .usb_in_full(usb_in_full)
   );

   logic [15:0] host_val = '0;
   assign usb_fd = !usb_oe_n ? host_val : 16'bz;

   int errors = 0, checks = 0;
   logic [15:0] exp_data[$];
   logic [15:0] exp_cmd[$];
   logic [15:0] host_cmd[$];
   int in_space = 0;
   int n_wr = 0, n_rd = 0, model_occ = 0;
   bit pend_pop = 0;
   logic [1:0] prev_ep = 2'b00;
   logic empty_seen = 1'b1, full_seen = 1'b1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void refresh_host();
      usb_out_empty = (host_cmd.size() == 0);
      host_val = (host_cmd.size() != 0) ? host_cmd[0] : 16'h0000;
      usb_in_full = (in_space == 0);
   endfunction

   always @(posedge clk) begin
      empty_seen <= usb_out_empty;
      full_seen  <= usb_in_full;
   end

   // monitor / host model
   always @(negedge clk) begin
      if (rst_n) begin
         if (!usb_rd_n || !usb_wr_n)
            check(usb_ep == prev_ep, "R6 ep moved before strobe", 32'(usb_ep), 32'(prev_ep));
         if (!usb_wr_n) begin
            n_wr++;
            check(usb_ep == 2'b10, "R2 write endpoint", 32'(usb_ep), 32'h2);
            check(!full_seen, "R4 write into full endpoint", 32'(full_seen), 32'h0);
            check(empty_seen, "R5 data before pending command", 32'(empty_seen), 32'h1);
            if (exp_data.size() == 0)
               check(1'b0, "R9 unexpected half on bus", 32'(usb_fd), 32'h0);
            else begin
               logic [15:0] e;
               e = exp_data.pop_front();
               check(usb_fd == e, "R2 data half", 32'(usb_fd), 32'(e));
            end
            if (in_space > 0) in_space--;
         end
         if (!usb_rd_n) begin
            n_rd++;
            check(usb_ep == 2'b00, "R3 read endpoint", 32'(usb_ep), 32'h0);
            check(!usb_oe_n, "R3 oe with rd", 32'(usb_oe_n), 32'h0);
            check(!empty_seen, "R4 read from empty endpoint", 32'(empty_seen), 32'h0);
         end
         if (!usb_oe_n)
            check(usb_fd == host_val, "R7 bus released while reading", 32'(usb_fd), 32'(host_val));
         if (cmd_valid) begin
            if (exp_cmd.size() == 0)
               check(1'b0, "R3 unexpected command", 32'(cmd_word), 32'h0);
            else begin
               logic [15:0] e;
               e = exp_cmd.pop_front();
               check(cmd_word == e, "R3 command word", 32'(cmd_word), 32'(e));
            end
         end
         if (pend_pop) begin
            void'(host_cmd.pop_front());
            pend_pop = 0;
         end
         if (!usb_rd_n) pend_pop = 1;
         refresh_host();
      end
      prev_ep = usb_ep;
   end

   task automatic set_space(input int s);
      @(posedge clk); #2;
      in_space = s;
      refresh_host();
   endtask

   task automatic push_burst(input int n, input int base, input bit model_full);
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         @(posedge clk); #2;
         w = {16'hA000 + 16'(base + i), 16'h5000 + 16'(base + i)};
         up_push = 1'b1;
         up_word = w;
         if (!model_full || model_occ < DEPTH) begin
            exp_data.push_back(w[15:0]);
            exp_data.push_back(w[31:16]);
            model_occ++;
         end
      end
      @(posedge clk); #2;
      up_push = 1'b0;
   endtask

   task automatic load_cmds(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         host_cmd.push_back(16'hC300 + 16'(base + i));
         exp_cmd.push_back(16'hC300 + 16'(base + i));
         refresh_host();
      end
   endtask

   task automatic wait_drain();
      int t;
      t = 0;
      while ((exp_data.size() != 0 || exp_cmd.size() != 0) && t < 5000) begin
         @(posedge clk);
         t++;
      end
      check(t < 5000, "drain timeout", 32'(exp_data.size()), 32'h0);
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int w0, r0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      check(usb_rd_n && usb_wr_n && usb_oe_n, "R1 strobes in reset",
            {29'd0, usb_rd_n, usb_wr_n, usb_oe_n}, 32'h7);
      check(usb_ep == 2'b00 && !cmd_valid, "R1 ep/valid in reset", {30'd0, usb_ep} | 32'(cmd_valid) << 4, 32'h0);
      @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 first cycle after reset
      check(up_empty && !up_full && drop_count == 0, "R1 buffer flags after reset",
            {up_empty, up_full, 27'd0, drop_count}, 32'h80000000);
      check(usb_rd_n && usb_wr_n && usb_ep == 2'b00, "R1 bus idle after reset",
            {28'd0, usb_rd_n, usb_wr_n, usb_ep}, 32'hC);

      // R2 streaming with overlapping push and pop
      set_space(100000);
      push_burst(10, 0, 1'b0);
      wait_drain();
      check(up_empty, "R8 empty after drain", 32'(up_empty), 32'h1);

      // R3 commands
      load_cmds(3, 0);
      wait_drain();
      check(n_rd == 3, "R3 read count", 32'(n_rd), 32'd3);

      // R4 / R8 flags and partial word
      set_space(0);
      w0 = n_wr; r0 = n_rd;
      push_burst(2, 20, 1'b0);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(n_wr == w0, "R4 no write while full", 32'(n_wr), 32'(w0));
      check(n_rd == r0, "R4 no read while empty", 32'(n_rd), 32'(r0));
      check(!up_empty, "R8 not empty while held", 32'(up_empty), 32'h0);
      set_space(1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(n_wr == w0 + 1, "R4 one write for one slot", 32'(n_wr), 32'(w0 + 1));
      check(!up_empty, "R8 partial word still held", 32'(up_empty), 32'h0);
      set_space(100000);
      wait_drain();

      // R5 / R6 command arriving during data stream
      set_space(0);
      push_burst(6, 40, 1'b0);
      set_space(100000);
      repeat (3) @(posedge clk);
      r0 = n_rd;
      load_cmds(2, 8);
      wait_drain();
      check(n_rd == r0 + 2, "R5 commands served", 32'(n_rd), 32'(r0 + 2));
      check(up_empty, "R8 empty after mixed traffic", 32'(up_empty), 32'h1);

      // R8 / R9 fill, drop, saturate
      set_space(0);
      model_occ = 0;
      push_burst(DEPTH, 100, 1'b1);
      @(negedge clk);
      check(up_full, "R8 full at DEPTH", 32'(up_full), 32'h1);
      check(drop_count == 0, "R9 no drop yet", 32'(drop_count), 32'h0);
      push_burst(3, 200, 1'b1);
      @(negedge clk);
      check(drop_count == 3, "R9 drop count", 32'(drop_count), 32'h3);
      push_burst(6, 300, 1'b1);
      @(negedge clk);
      check(drop_count == 7, "R9 drop saturates", 32'(drop_count), 32'h7);
      set_space(1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(up_full, "R8 full with half sent", 32'(up_full), 32'h1);
      set_space(100000);
      wait_drain();
      @(negedge clk);
      check(!up_full && up_empty, "R8 flags after full drain", {30'd0, up_full, up_empty}, 32'h1);
      check(drop_count == 7, "R9 count holds", 32'(drop_count), 32'h7);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule